// File: doc/BRIEF.md
# Spectral Noise Subtraction Unit

This block turns a pair of per-bin magnitudes into one noise-reduced magnitude. For every frequency bin it receives the magnitude of the noisy signal and an estimate of the noise magnitude in the same bin. It scales the noise estimate by an over-subtraction factor and removes it from the signal magnitude. It also forms a spectral floor by scaling the same noise estimate by a separate, much smaller factor. A comparator then picks whichever of the two is larger. Over-subtraction therefore never drives a bin below the floor, and the result never wraps.

Both factors are unsigned fixed-point numbers with four fractional bits. Each is held in its own register that loads from a plain configuration port and returns to a preset value on reset: 2.0 for the over-subtraction factor and 0.0625 for the floor factor. Bins arrive on a valid/ready stream and leave on another. A transfer happens on any clock edge where valid and ready are both high. The input may be offered at any time and must be held stable until it is taken. The output holds its data and its valid flag for as long as the sink keeps ready low. The two-stage pipeline can hold two bins while the output is stalled.

Top module: `snr_subtract_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The over-subtraction factor is 0x20 (2.0) and the floor factor is 0x01 (0.0625).
- R2: The scaled noise is floor(alpha*B/16), where alpha is the 8-bit factor with 4 fractional bits. When A minus the scaled noise is greater than the floor, `out_mag` equals that difference.
- R3: The floor is floor(beta*B/16), where beta is the 8-bit factor with 4 fractional bits. A floor above 65535 saturates to 65535.
- R4: `out_mag` equals the difference only when the difference is strictly greater than the floor. Otherwise it equals the floor. With alpha = 0 the output is max(A, floor).
- R5: A negative difference always yields the floor. It never yields a wrapped 16-bit value.
- R6: With `out_ready` held high, a bin taken at clock edge k appears with `out_valid` high after edge k+1, two cycles of latency. One result per cycle is sustained.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_mag` stays unchanged. No bin is lost, and bins leave in the order they were taken.
- R8: `in_ready` is 0 only when both stages hold bins and the output is stalled.
- R9: When `cfg_we` is high at an edge, `cfg_value` loads the over-subtraction factor (`cfg_sel` = 0) or the floor factor (`cfg_sel` = 1). A bin taken at that same edge still uses the old factor. Bins taken at later edges use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Factor write strobe |
| cfg_sel | input | 1 | 0: over-subtraction factor, 1: floor factor |
| cfg_value | input | 8 | Factor value, 4 fractional bits |
| in_valid | input | 1 | Input bin offered |
| in_ready | output | 1 | Input bin can be taken |
| in_sig | input | 16 | Noisy signal magnitude A |
| in_noise | input | 16 | Noise estimate magnitude B |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Sink takes the result |
| out_mag | output | 16 | Noise-reduced magnitude |

## Verification
A factor write and a bin transfer can fall on the same clock edge. In that case the bin must use the factor value from before the write. The bench provokes this by raising `cfg_we` and `in_valid` in the same cycle. It then checks that this bin comes out with the old factor and that the next bin uses the new one. A stalled output and an offered input can also coincide. The bench holds `out_ready` low while a third bin waits, and judges `in_ready`, the held `out_mag` and the order of the results once the stall clears.

// File: rtl/snr_pkg.sv
package snr_pkg;
  localparam int unsigned MAG_W_DEF  = 16;
  localparam int unsigned FAC_W_DEF  = 8;
  localparam int unsigned FRAC_W_DEF = 4;

  typedef enum logic {
    CFG_OVERSUB = 1'b0,
    CFG_FLOOR   = 1'b1
  } cfg_target_e;
endpackage

// File: rtl/snr_factor_regs.sv
module snr_factor_regs #(
  parameter int unsigned FAC_W     = 8,
  parameter logic [FAC_W-1:0] OVER_RST  = 8'h20,
  parameter logic [FAC_W-1:0] FLOOR_RST = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [FAC_W-1:0] wr_value,
  output logic [FAC_W-1:0] over_fac,
  output logic [FAC_W-1:0] floor_fac
);
  import snr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_fac  <= OVER_RST;
      floor_fac <= FLOOR_RST;
    end else if (wr_en) begin
      if (wr_sel == CFG_OVERSUB) over_fac  <= wr_value;
      else                       floor_fac <= wr_value;
    end
  end
endmodule

// File: rtl/snr_scale.sv
module snr_scale #(
  parameter int unsigned MAG_W  = 16,
  parameter int unsigned FAC_W  = 8,
  parameter int unsigned FRAC_W = 4,
  parameter int unsigned OUT_W  = 20
) (
  input  logic [MAG_W-1:0] mag,
  input  logic [FAC_W-1:0] fac,
  output logic [OUT_W-1:0] scaled
);
  localparam int unsigned PROD_W = MAG_W + FAC_W;
  localparam int unsigned INT_W  = PROD_W - FRAC_W;

  logic [PROD_W-1:0] prod;
  logic [INT_W-1:0]  whole;

  always_comb begin
    prod  = PROD_W'(mag) * PROD_W'(fac);
    whole = prod[PROD_W-1:FRAC_W];
  end

  generate
    if (OUT_W >= INT_W) begin : g_wide
      assign scaled = OUT_W'(whole);
    end else begin : g_sat
      logic over;
      assign over   = |whole[INT_W-1:OUT_W];
      assign scaled = over ? {OUT_W{1'b1}} : whole[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/snr_decide.sv
module snr_decide #(
  parameter int unsigned MAG_W  = 16,
  parameter int unsigned DIFF_W = 21
) (
  input  logic signed [DIFF_W-1:0] diff,
  input  logic        [MAG_W-1:0]  floor_mag,
  output logic        [MAG_W-1:0]  result
);
  logic signed [DIFF_W-1:0] floor_ext;
  logic                     take_diff;

  always_comb begin
    floor_ext = $signed({{(DIFF_W-MAG_W){1'b0}}, floor_mag});
    take_diff = diff > floor_ext;
    result    = take_diff ? diff[MAG_W-1:0] : floor_mag;
  end
endmodule

// File: rtl/snr_subtract_top.sv
module snr_subtract_top #(
  parameter int unsigned MAG_W  = snr_pkg::MAG_W_DEF,
  parameter int unsigned FAC_W  = snr_pkg::FAC_W_DEF,
  parameter int unsigned FRAC_W = snr_pkg::FRAC_W_DEF,
  parameter logic [FAC_W-1:0] OVER_RST  = 8'h20,
  parameter logic [FAC_W-1:0] FLOOR_RST = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [FAC_W-1:0] cfg_value,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MAG_W-1:0] in_sig,
  input  logic [MAG_W-1:0] in_noise,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAG_W-1:0] out_mag
);
  localparam int unsigned SCL_W  = MAG_W + FAC_W - FRAC_W;
  localparam int unsigned DIFF_W = SCL_W + 1;

  logic [FAC_W-1:0] alpha_q, beta_q;

  snr_factor_regs #(.FAC_W(FAC_W), .OVER_RST(OVER_RST), .FLOOR_RST(FLOOR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_value(cfg_value), .over_fac(alpha_q), .floor_fac(beta_q)
  );

  logic [SCL_W-1:0] noise_scaled;
  logic [MAG_W-1:0] floor_c;

  snr_scale #(.MAG_W(MAG_W), .FAC_W(FAC_W), .FRAC_W(FRAC_W), .OUT_W(SCL_W)) u_over (
    .mag(in_noise), .fac(alpha_q), .scaled(noise_scaled)
  );
  snr_scale #(.MAG_W(MAG_W), .FAC_W(FAC_W), .FRAC_W(FRAC_W), .OUT_W(MAG_W)) u_floor (
    .mag(in_noise), .fac(beta_q), .scaled(floor_c)
  );

  logic signed [DIFF_W-1:0] diff_c;
  always_comb begin
    diff_c = $signed({{(DIFF_W-MAG_W){1'b0}}, in_sig}) - $signed({1'b0, noise_scaled});
  end

  // Handshake: each stage moves when the one after it moves or is empty.
  logic s1_valid, s2_adv, s1_adv;
  assign s2_adv   = out_ready || !out_valid;
  assign s1_adv   = s2_adv || !s1_valid;
  assign in_ready = s1_adv;

  logic signed [DIFF_W-1:0] s1_diff;
  logic        [MAG_W-1:0]  s1_floor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_diff  <= '0;
      s1_floor <= '0;
    end else if (s1_adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_diff  <= diff_c;
        s1_floor <= floor_c;
      end
    end
  end

  logic [MAG_W-1:0] pick_c;
  snr_decide #(.MAG_W(MAG_W), .DIFF_W(DIFF_W)) u_decide (
    .diff(s1_diff), .floor_mag(s1_floor), .result(pick_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
    end else if (s2_adv) begin
      out_valid <= s1_valid;
      if (s1_valid) out_mag <= pick_c;
    end
  end
endmodule

// File: rtl/snr_subtract_chk.sv
module snr_subtract_chk #(
  parameter int unsigned MAG_W = 16,
  parameter int unsigned FAC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_sel,
  input logic [FAC_W-1:0] cfg_value,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MAG_W-1:0] out_mag,
  input logic [FAC_W-1:0] alpha,
  input logic [FAC_W-1:0] beta,
  input logic             s1_v,
  input logic             s1_neg,
  input logic [MAG_W-1:0] s1_floor
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mag)));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  p_alpha_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (alpha == $past(cfg_value)));

  p_beta_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (beta == $past(cfg_value)));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_neg && (out_ready || !out_valid)) |=> (out_valid && out_mag == $past(s1_floor)));
endmodule

bind snr_subtract_top snr_subtract_chk #(.MAG_W(MAG_W), .FAC_W(FAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_value(cfg_value),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready), .out_mag(out_mag),
  .alpha(alpha_q), .beta(beta_q), .s1_v(s1_valid), .s1_neg(s1_diff[DIFF_W-1]),
  .s1_floor(s1_floor)
);

// File: tb/snr_subtract_tb.sv
module snr_subtract_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_value = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_sig = '0, in_noise = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [15:0] out_mag;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  int exp_q[$];
  int alpha_m = 32, beta_m = 1;

  always #4 clk = ~clk;

  snr_subtract_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_value(cfg_value),
    .in_valid(in_valid), .in_ready(in_ready), .in_sig(in_sig), .in_noise(in_noise),
    .out_valid(out_valid), .out_ready(out_ready), .out_mag(out_mag)
  );

  function automatic int model(int a, int b, int al, int be);
    int sc, fl, d;
    sc = (b * al) / 16;
    fl = (b * be) / 16;
    if (fl > 65535) fl = 65535;
    d = a - sc;
    return (d > fl) ? d : fl;
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: samples between edges; handshakes seen here complete at the next edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      alpha_m = 32; beta_m = 1;
    end else begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk({cur_req, " unexpected output"}, int'(out_mag), -1);
        else chk(cur_req, int'(out_mag), exp_q.pop_front());
      end
      if (in_valid && in_ready)
        exp_q.push_back(model(int'(in_sig), int'(in_noise), alpha_m, beta_m));
      if (cfg_we) begin
        if (cfg_sel) beta_m = int'(cfg_value);
        else         alpha_m = int'(cfg_value);
      end
    end
  end

  task automatic send(int a, int b);
    logic acc;
    in_valid = 1'b1; in_sig = 16'(a); in_noise = 16'(b);
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(logic sel, int v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_value = 8'(v);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(posedge clk);
    #1;
    chk({cur_req, " drain"}, exp_q.size(), 0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    @(posedge clk); #1;
    send(1000, 100);              // defaults: 1000-200=800 > 6
    drain();
  endtask

  task automatic t_subtract();
    cur_req = "R2";
    send(5000, 1000);
    send(40000, 300);
    cfg_write(1'b0, 8'h30);       // alpha 3.0
    send(40000, 300);
    cfg_write(1'b0, 8'h18);       // alpha 1.5: 7*1.5=10.5 -> 10
    send(50, 7);
    drain();
  endtask

  task automatic t_floor();
    cur_req = "R3";
    cfg_write(1'b0, 8'h20);
    cfg_write(1'b1, 8'h18);       // beta 1.5: 7 -> 10
    send(5, 7);
    cfg_write(1'b1, 8'hFF);       // saturates
    send(100, 65535);
    drain();
  endtask

  task automatic t_alpha_zero();
    cur_req = "R4";
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h10);
    send(500, 200);
    send(150, 200);
    send(200, 200);
    drain();
  endtask

  task automatic t_negative();
    cur_req = "R5";
    cfg_write(1'b0, 8'h20);
    cfg_write(1'b1, 8'h01);
    send(100, 1000);              // diff -1900 -> floor 62
    send(0, 65535);
    drain();
  endtask

  task automatic t_latency();
    int n;
    cur_req = "R6";
    in_valid = 1'b1; in_sig = 16'd3000; in_noise = 16'd10;
    @(posedge clk); #1;
    in_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!out_valid && n < 10);
    chk("R6 latency", n, 2);
    drain();
    in_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      in_sig = 16'(1000 + i * 37); in_noise = 16'(i * 11);
      @(negedge clk); chk("R6 in_ready stream", int'(in_ready), 1);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    drain();
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    cur_req = "R7";
    out_ready = 1'b0;
    send(900, 50);
    send(800, 40);
    in_valid = 1'b1; in_sig = 16'd700; in_noise = 16'd30;
    @(negedge clk);
    held = out_mag;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 in_ready stalled", int'(in_ready), 0);
      chk("R7 out_valid held", int'(out_valid), 1);
      chk("R7 out_mag held", int'(out_mag), int'(held));
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    send(700, 30);
    drain();
  endtask

  task automatic t_same_cycle();
    cur_req = "R9";
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_value = 8'h10;
    in_valid = 1'b1; in_sig = 16'd1000; in_noise = 16'd100;
    @(negedge clk);
    chk("R9 in_ready", int'(in_ready), 1);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    in_sig = 16'd1000; in_noise = 16'd100;
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_subtract();
    t_floor();
    t_alpha_zero();
    t_negative();
    t_latency();
    t_backpressure();
    t_same_cycle();
    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule